// File: doc/BRIEF.md
# Trigger Window Hit Matcher

This block sits between a derandomizing hit buffer and the output link of a pixel readout chain. Hit words arrive on a valid/ready stream. Each word carries a column address, a row address and an 8-bit time stamp that counts 25 ns bunch-crossing periods. The block leaves on a valid/ready stream of hit words. A single configuration bit selects one of two modes. In the pass-through mode, every hit goes straight from input to output without any register in the path.

In the triggered mode, hits are held in a ring buffer in the order they arrived. A trigger pulse fixes a reference stamp, which is the shared bunch-crossing count minus a programmed latency, wrapped modulo 256. The scanner then walks the whole buffer and forwards every hit whose stamp lies within ±N stamp values of the reference, where N is a configurable half-width. Differences are taken as signed 8-bit values, so the window works across counter wrap. A hit that has aged past the latency plus the half-width is removed from the head of the buffer while no trigger is waiting, so stale hits do not fill it. Triggers that arrive during a scan wait in a small FIFO. A trigger lost to a full FIFO sets a sticky error flag.

Top module: `trig_window_matcher`

## Requirements
- R1: After reset, out_valid is 0 and trig_overflow is 0. In triggered mode, hit_ready is 1 because the buffer is empty.
- R2: A hit word holds its time stamp in bits [7:0], the row address in bits [17:8] and the column address in bits [26:18]. Bits [31:27] are zero, and a forwarded word is bit-identical to the word that was accepted.
- R3: With cfg_trig_mode = 0, out_valid equals hit_valid, out_word equals hit_word and hit_ready equals out_ready in the same cycle.
- R4: Trigger pulses that arrive while cfg_trig_mode = 0 are discarded. They cause no output after a later switch to triggered mode.
- R5: The reference stamp of a trigger is (bx_time − cfg_latency) mod 256, sampled at the clock edge where trig_pulse is 1.
- R6: In triggered mode, a buffered hit is forwarded for a trigger exactly when d = (hit_ts − ref) mod 256, read as a signed 8-bit value, satisfies −cfg_half_win ≤ d ≤ cfg_half_win. The bounds are inclusive, and the test holds across stamp wrap.
- R7: The hits forwarded for one trigger leave in the order in which they were accepted.
- R8: Up to 4 triggers, counting the one being scanned, are held. Queued triggers are served in arrival order.
- R9: A trigger that arrives while 4 are held and none is completing sets trig_overflow. The flag stays 1 until reset.
- R10: While out_valid = 1 and out_ready = 0, out_valid stays 1 and out_word is unchanged on the next cycle.
- R11: In triggered mode, hit_ready is 0 whenever HIT_DEPTH (16) hits are buffered.
- R12: While no trigger is held, a head hit with (ref_now − hit_ts) mod 256 as a signed value greater than cfg_half_win is dropped, one per cycle, without being forwarded. Here ref_now is (bx_time − cfg_latency) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_trig_mode | input | 1 | 1 = triggered window matching, 0 = pass-through |
| cfg_latency | input | 8 | Trigger latency in bunch-crossing periods |
| cfg_half_win | input | 4 | Window half-width N in stamp values |
| bx_time | input | 8 | Shared bunch-crossing count |
| hit_valid | input | 1 | Input hit word is valid |
| hit_ready | output | 1 | Input hit word is accepted |
| hit_word | input | 32 | Input hit: column, row, time stamp |
| trig_pulse | input | 1 | Trigger strobe, one entry per high cycle |
| out_valid | output | 1 | Output hit word is valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | 32 | Forwarded hit word |
| trig_overflow | output | 1 | Sticky flag: a trigger was lost |

## Verification
The assertions check several rules on every cycle. They cover the pass-through equalities and the output hold under backpressure. They also check that a loaded output word lies inside the window of the trigger that picked it and that the buffer refuses input when full. Further checks are that purging happens only with the scanner idle, that the trigger count stays within bounds and that the overflow flag stays set. Other behaviours can only be shown by the bench scenarios. These are which hits are selected at the inclusive window edges and across stamp wrap, the order of the output, that triggers are served in sequence and that triggers sent in pass-through mode are forgotten. The same applies to the freeing of a full buffer once its contents turn stale.

// File: rtl/trigmatch_pkg.sv
package trigmatch_pkg;
  localparam int TS_W    = 8;
  localparam int ROW_W   = 10;
  localparam int COL_W   = 9;
  localparam int WORD_W  = 32;
  localparam int ROW_LSB = TS_W;
  localparam int COL_LSB = TS_W + ROW_W;

  typedef logic [TS_W-1:0]   ts_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic ts_t word_ts(word_t w);
    return w[TS_W-1:0];
  endfunction

  // reference stamp: bunch count minus latency, wrapping
  function automatic ts_t trig_stamp(ts_t now, ts_t lat);
    return ts_t'(now - lat);
  endfunction

  // signed modulo-2^TS_W distance a - b
  function automatic int ts_delta(ts_t a, ts_t b);
    logic signed [TS_W-1:0] d;
    d = signed'(ts_t'(a - b));
    return int'(d);
  endfunction

  function automatic logic in_window(ts_t ts, ts_t ref_ts, int half);
    int dv;
    dv = ts_delta(ts, ref_ts);
    return (dv >= -half) && (dv <= half);
  endfunction

  function automatic logic is_stale(ts_t ts, ts_t ref_now, int half);
    return ts_delta(ref_now, ts) > half;
  endfunction
endpackage

// File: rtl/tm_trig_queue.sv
module tm_trig_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         empty,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          full, do_push, do_pop, lost;

  assign full      = (count == FULL_CNT);
  assign empty     = (count == '0);
  assign do_pop    = pop && !empty;
  assign do_push   = push && (!full || do_pop);
  assign lost      = push && full && !do_pop;
  assign head_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; overflow <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (lost) overflow <= 1'b1;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_lost_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> overflow);
endmodule

// File: rtl/tm_hit_ring.sv
module tm_hit_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          pop,
  input  logic [AW-1:0] rd_off,
  output logic [W-1:0]  rd_data,
  output logic [AW:0]   count,
  output logic          full
);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head, tail, rd_idx;
  logic [AW:0]   off_sum;
  logic          do_wr, do_pop;

  assign full    = (count == FULL_CNT);
  assign do_pop  = pop && (count != '0);
  assign do_wr   = wr_en && !full;
  assign off_sum = {1'b0, head} + {1'b0, rd_off};
  assign rd_idx  = (off_sum >= FULL_CNT) ? AW'(off_sum - FULL_CNT) : AW'(off_sum);
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (do_wr) mem[tail] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; count <= '0;
    end else begin
      if (do_wr)  tail <= (tail == LAST_IDX) ? '0 : tail + 1'b1;
      if (do_pop) head <= (head == LAST_IDX) ? '0 : head + 1'b1;
      case ({do_wr, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_write_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    full && !do_pop |=> count == FULL_CNT);
endmodule

// File: rtl/trig_window_matcher.sv
module trig_window_matcher
  import trigmatch_pkg::*;
#(
  parameter int HIT_DEPTH  = 16,
  parameter int TRIG_DEPTH = 4,
  parameter int WIN_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_trig_mode,
  input  logic [TS_W-1:0]   cfg_latency,
  input  logic [WIN_W-1:0]  cfg_half_win,
  input  logic [TS_W-1:0]   bx_time,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [WORD_W-1:0] hit_word,
  input  logic              trig_pulse,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              trig_overflow
);
  localparam int AW = (HIT_DEPTH > 1) ? $clog2(HIT_DEPTH) : 1;

  // named internal events
  logic        tq_empty, ring_full, scan_adv, scan_at_end, scan_done, hit_match, purge;
  ts_t         cur_ref, ref_now;
  word_t       entry;
  logic [AW:0] ring_count, scan_off;
  logic        ov_q;
  word_t       od_q;
  int          half;

  assign half    = int'(cfg_half_win);
  assign ref_now = trig_stamp(bx_time, cfg_latency);

  tm_trig_queue #(.DEPTH(TRIG_DEPTH), .W(TS_W)) u_tq (
    .clk(clk), .rst_n(rst_n),
    .push(cfg_trig_mode && trig_pulse), .push_data(ref_now),
    .pop(scan_done), .head_data(cur_ref), .empty(tq_empty),
    .overflow(trig_overflow)
  );

  tm_hit_ring #(.DEPTH(HIT_DEPTH), .W(WORD_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_trig_mode && hit_valid), .wr_data(hit_word),
    .pop(purge), .rd_off(scan_off[AW-1:0]), .rd_data(entry),
    .count(ring_count), .full(ring_full)
  );

  assign scan_adv    = cfg_trig_mode && !tq_empty && (!ov_q || out_ready);
  assign scan_at_end = (scan_off == ring_count);
  assign scan_done   = scan_adv && scan_at_end;
  assign hit_match   = scan_adv && !scan_at_end && in_window(word_ts(entry), cur_ref, half);
  // idle scanner reads offset 0, i.e. the head entry
  assign purge       = cfg_trig_mode && tq_empty && (ring_count != '0)
                       && is_stale(word_ts(entry), ref_now, half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_off <= '0;
      ov_q     <= 1'b0;
      od_q     <= '0;
    end else begin
      if (scan_done)                   scan_off <= '0;
      else if (scan_adv && !scan_at_end) scan_off <= scan_off + 1'b1;
      if (hit_match) begin
        ov_q <= 1'b1;
        od_q <= entry;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign hit_ready = cfg_trig_mode ? !ring_full : out_ready;
  assign out_valid = cfg_trig_mode ? ov_q : hit_valid;
  assign out_word  = cfg_trig_mode ? od_q : hit_word;

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_trig_mode |-> (out_valid == hit_valid) && (out_word == hit_word)
                       && (hit_ready == out_ready));
  assert_ts_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_match |=> out_valid && in_window(word_ts(out_word), $past(cur_ref), $past(half)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_trig_mode && out_valid && !out_ready |=> out_valid && $stable(out_word));
  assert_full_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_trig_mode && ring_full |-> !hit_ready);
  assert_purge_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    purge |-> tq_empty && (scan_off == '0) && !hit_match);
endmodule

// File: tb/trig_window_matcher_bench.sv
`timescale 1ns/1ps
module trig_window_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_trig_mode;
  logic [7:0]  cfg_latency;
  logic [3:0]  cfg_half_win;
  logic [7:0]  bx_time;
  logic        hit_valid;
  logic        hit_ready;
  logic [31:0] hit_word;
  logic        trig_pulse;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_word;
  logic        trig_overflow;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int rdy_mode = 1; // 0 random, 1 high, 2 low
  logic [31:0] got[$];
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  trig_window_matcher u_trig_window_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_trig_mode(cfg_trig_mode),
    .cfg_latency(cfg_latency), .cfg_half_win(cfg_half_win), .bx_time(bx_time),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_word(hit_word),
    .trig_pulse(trig_pulse), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .trig_overflow(trig_overflow)
  );

  always @(posedge clk)
    if (rst_n && out_valid && out_ready) got.push_back(out_word);

  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0:       out_ready = ($urandom % 4) != 0;
        2:       out_ready = 1'b0;
        default: out_ready = 1'b1;
      endcase
    end
  end

  function automatic logic [31:0] mk_word(int col, int row, int ts);
    return {5'b0, col[8:0], row[9:0], ts[7:0]};
  endfunction

  function automatic int b_dist(int a, int b);
    int d;
    d = (a - b) & 255;
    if (d >= 128) d = d - 256;
    return d;
  endfunction

  function automatic bit b_match(int ts, int rf, int w);
    int d;
    d = b_dist(ts, rf);
    return (d <= w) && (d >= -w);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_got(string tag);
    bit ok;
    int bad;
    ok = (got.size() == exp_q.size());
    bad = -1;
    if (ok)
      foreach (exp_q[i]) if (bad < 0 && got[i] !== exp_q[i]) bad = i;
    if (!ok) check(0, {tag, " count"}, got.size(), exp_q.size());
    else if (bad >= 0) check(0, tag, got[bad], exp_q[bad]);
    else check(1, tag, 0, 0);
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_hit(logic [31:0] w);
    logic r;
    @(negedge clk);
    hit_valid = 1'b1;
    hit_word  = w;
    forever begin
      #1 r = hit_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig_pulse = 1'b1;
    @(negedge clk);
    trig_pulse = 1'b0;
  endtask

  task automatic flush(int next_bx);
    @(negedge clk);
    bx_time = bx_time + 8'd100;
    cycles(24);
    bx_time = next_bx[7:0];
    got.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int rf;
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; cfg_trig_mode = 1'b1; cfg_latency = 8'd40; cfg_half_win = 4'd3;
    bx_time = 8'd100; hit_valid = 1'b0; hit_word = '0; trig_pulse = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(trig_overflow == 1'b0, "R1 overflow after reset", trig_overflow, 0);
    check(hit_ready == 1'b1, "R1 hit_ready after reset", hit_ready, 1);

    // R3: pass-through
    cfg_trig_mode = 1'b0;
    rdy_mode = 0;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] w;
      @(negedge clk);
      w = mk_word($urandom % 512, $urandom % 1024, $urandom % 256);
      hit_valid = $urandom % 2;
      hit_word  = w;
      #1;
      check(out_valid == hit_valid && out_word == w && hit_ready == out_ready,
            "R3 pass-through", {out_valid, hit_ready, out_word[29:0]},
            {hit_valid, out_ready, w[29:0]});
    end
    @(negedge clk);
    hit_valid = 1'b0;
    rdy_mode = 1;

    // R4: triggers in pass-through are forgotten
    pulse_trig();
    pulse_trig();
    @(negedge clk);
    cfg_trig_mode = 1'b1;
    got.delete();
    rf = (100 - 40) & 255;
    for (int i = 0; i < 3; i++) send_hit(mk_word(i + 1, 7, rf));
    cycles(30);
    check(got.size() == 0, "R4 no output from pass-through triggers", got.size(), 0);
    flush(100);

    // R6/R5/R2: inclusive window edges
    rf = (100 - 40) & 255;
    for (int d = -4; d <= 4; d++) begin
      logic [31:0] w;
      w = mk_word(200 + d, 300 + d, (rf + d) & 255);
      send_hit(w);
      if (b_match((rf + d) & 255, rf, 3)) exp_q.push_back(w);
    end
    pulse_trig();
    cycles(40);
    check_got("R6 window edges, R5 reference stamp");
    if (got.size() > 0) begin
      check(got[0][26:18] == 9'd197, "R2 column field", got[0][26:18], 197);
      check(got[0][17:8] == 10'd297 && got[0][31:27] == 5'd0, "R2 row field",
            got[0][17:8], 297);
    end

    // R6 wrap
    flush(41);
    rf = 1;
    for (int k = 0; k < 6; k++) begin
      int ts;
      logic [31:0] w;
      ts = (k == 0) ? 253 : (k == 1) ? 254 : (k == 2) ? 255 : (k == 3) ? 1 : (k == 4) ? 4 : 5;
      w = mk_word(k, 11, ts);
      send_hit(w);
      if (b_match(ts, rf, 3)) exp_q.push_back(w);
    end
    pulse_trig();
    cycles(40);
    check_got("R6 window across wrap");
    check(exp_q.size() == 4, "R6 bench wrap expectation", exp_q.size(), 4);

    // R7: random rounds with random backpressure
    rdy_mode = 0;
    for (int r = 0; r < 10; r++) begin
      int b, n, w, lat;
      flush(0);
      lat = 20 + ($urandom % 180);
      w   = $urandom % 8;
      b   = $urandom % 256;
      @(negedge clk);
      cfg_latency = lat[7:0];
      cfg_half_win = w[3:0];
      bx_time = b[7:0];
      rf = (b - lat) & 255;
      n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++) begin
        int d, ts;
        logic [31:0] hw;
        d  = int'($urandom % (2 * w + 7)) - (w + 3);
        ts = (rf + d) & 255;
        hw = mk_word($urandom % 512, $urandom % 1024, ts);
        send_hit(hw);
        if (b_match(ts, rf, w)) exp_q.push_back(hw);
      end
      pulse_trig();
      cycles(80);
      check_got("R7 random round order and R6 selection");
    end
    rdy_mode = 1;

    // R8: queued triggers served in order
    flush(100);
    @(negedge clk);
    cfg_latency = 8'd40;
    cfg_half_win = 4'd1;
    send_hit(mk_word(1, 1, 80));
    send_hit(mk_word(2, 2, 60));
    send_hit(mk_word(3, 3, 70));
    send_hit(mk_word(4, 4, 61));
    exp_q.push_back(mk_word(2, 2, 60));
    exp_q.push_back(mk_word(4, 4, 61));
    exp_q.push_back(mk_word(3, 3, 70));
    exp_q.push_back(mk_word(1, 1, 80));
    @(negedge clk);
    bx_time = 8'd100; trig_pulse = 1'b1;
    @(negedge clk);
    bx_time = 8'd110;
    @(negedge clk);
    bx_time = 8'd120;
    @(negedge clk);
    trig_pulse = 1'b0;
    cycles(40);
    check_got("R8 trigger queue order");

    // R9: overflow sticky
    flush(100);
    @(negedge clk);
    cfg_half_win = 4'd3;
    for (int i = 0; i < 10; i++) send_hit(mk_word(i, i, 62));
    check(trig_overflow == 1'b0, "R9 no overflow before burst", trig_overflow, 0);
    @(negedge clk);
    trig_pulse = 1'b1;
    cycles(4);
    #1;
    check(trig_overflow == 1'b0, "R8 four triggers held without loss", trig_overflow, 0);
    @(negedge clk);
    trig_pulse = 1'b0;
    #1;
    check(trig_overflow == 1'b1, "R9 fifth trigger overflows", trig_overflow, 1);
    cycles(120);
    check(trig_overflow == 1'b1, "R9 flag sticky", trig_overflow, 1);
    check(got.size() == 40, "R8 four scans forwarded", got.size(), 40);

    // R10: hold under backpressure
    flush(100);
    rdy_mode = 2;
    send_hit(mk_word(9, 9, 60));
    send_hit(mk_word(8, 8, 61));
    pulse_trig();
    cycles(10);
    #1;
    check(out_valid == 1'b1 && out_word == mk_word(9, 9, 60), "R10 held word",
          out_word, mk_word(9, 9, 60));
    cycles(5);
    #1;
    check(out_valid == 1'b1 && out_word == mk_word(9, 9, 60), "R10 still held",
          out_word, mk_word(9, 9, 60));
    rdy_mode = 1;
    exp_q.push_back(mk_word(9, 9, 60));
    exp_q.push_back(mk_word(8, 8, 61));
    cycles(20);
    check_got("R10 released in order");

    // R11/R12: fill with unmatched live hits, then age them out
    flush(100);
    for (int i = 0; i < 16; i++) send_hit(mk_word(i, 5, 64));
    #1;
    check(hit_ready == 1'b0, "R11 full buffer stalls input", hit_ready, 0);
    @(negedge clk);
    bx_time = 8'd200;
    cycles(20);
    #1;
    check(hit_ready == 1'b1, "R12 stale hits purged", hit_ready, 1);
    check(got.size() == 0, "R12 purged hits not forwarded", got.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule